// File: doc/BRIEF.md
# Parallel Display Bus Master (8080-style)

This block turns single-word requests from on-chip logic into bus cycles on a 16-bit, 8080-style parallel link to a display controller. Each request names a direction (write or read), a data/command flag and, for writes, the word to send. On the pins the block produces an active-low chip select, an active-low write strobe, an active-low read strobe and a data/command line. The data/command line is low for a command code and high for a parameter or for RGB565 pixel data. The data bus leaves the block as separate pad signals: output word, output enable and input word. The pad ring builds the tri-state driver from them.

Every bus cycle has two phases, and each phase has a length set from 0 to 15 clocks. In the address-setup phase, chip select is low, the data/command level is valid and both strobes are high. In the strobe phase, the chosen strobe is low. A length of zero is stretched to one clock. A command sequence is built by the user from one request with the flag low, followed by any number of requests with the flag high.

Requests enter through a valid/ready port. `req_ready` is high only when the block is idle, so the requester must hold `req_valid` and its fields stable until a clock edge where both are high. The outcome leaves through a valid/ready response port. `rsp_valid` stays high, with `rsp_rdata` stable, until the consumer raises `rsp_ready`. No new request is taken while a response is still waiting.

Top module: `lcdbus_master`

## Requirements
- R1: After reset, `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are 1. `lcd_dq_oe`, `busy` and `rsp_valid` are 0, `req_ready` is 1 and `rsp_rdata` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `busy` is 1 for exactly the clocks in which `lcd_cs_n` is 0 for that request.
- R3: After acceptance, `lcd_cs_n` is 0 with both strobes 1 for A clocks, where A is `cfg_addr_setup` at acceptance, or 1 if that value is 0. `lcd_dc` equals `req_dc` (0 = command, 1 = data) and is stable while `lcd_cs_n` is 0.
- R4: The address-setup phase is followed by D clocks in which `lcd_wr_n` (for a write) or `lcd_rd_n` (for a read) is 0, with `lcd_cs_n` still 0. D is `cfg_data_setup` at acceptance, or 1 if that value is 0. The other strobe stays 1 and the two strobes are never low together.
- R5: For a write (`req_read`=0), `lcd_dq_oe` is 1 and `lcd_dq_o` equals `req_wdata` in every clock in which `lcd_cs_n` is 0. `lcd_dq_oe` is 0 whenever `lcd_cs_n` is 1.
- R6: For a read (`req_read`=1), `lcd_dq_oe` stays 0. `rsp_rdata` holds the value that `lcd_dq_i` had in the last clock of the read strobe.
- R7: A phase count of 0 gives a one-clock phase, so a request with both counts 0 holds `lcd_cs_n` low for exactly 2 clocks.
- R8: In the clock after the strobe rises, `lcd_cs_n` is 1 and `rsp_valid` is 1. `rsp_valid` and `req_ready`=0 hold until `rsp_ready` is 1. Back-to-back requests are separated by at least one clock with `lcd_cs_n` high.
- R9: A write leaves `rsp_rdata` unchanged.
- R10: Changes to `cfg_addr_setup` or `cfg_data_setup` after acceptance do not change the phase lengths of the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_read | input | 1 | 1 = read cycle, 0 = write cycle |
| req_dc | input | 1 | 0 = command word, 1 = parameter/pixel word |
| req_wdata | input | 16 | Word to write |
| cfg_addr_setup | input | 4 | Address-setup phase length in clocks (0 acts as 1) |
| cfg_data_setup | input | 4 | Strobe phase length in clocks (0 acts as 1) |
| rsp_valid | output | 1 | Cycle finished, response waiting |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 16 | Word captured by the latest read |
| busy | output | 1 | Bus cycle in progress |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dc | output | 1 | Data/command select |
| lcd_dq_o | output | 16 | Bus word to pad driver |
| lcd_dq_oe | output | 1 | Pad driver enable, 1 = drive |
| lcd_dq_i | input | 16 | Bus word from pad receiver |

## Verification
The hardest case to reach from the ports is showing that a read captures the bus in the last strobe clock and not in an earlier one. To reach it, the bench models the display side so that it changes the word on `lcd_dq_i` in every clock of the read strobe, counting up from a base value. A capture one clock early or late then gives a different result. Configuration changes made right after acceptance, and requests issued back to back while `rsp_ready` is held high, reach the latching and spacing behaviour that steady stimulus never touches.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_DONE = 2'd3
  } lcd_phase_e;

  function automatic logic phase_active(input lcd_phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_STRB);
  endfunction

endpackage

// File: rtl/lcdbus_phase_timer.sv
module lcdbus_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff_val;

  // a zero length is stretched to one clock
  assign eff_val = (load_val == '0) ? ONE : load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= eff_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/lcdbus_seq.sv
module lcdbus_seq
  import lcdbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             rsp_ready,
  input  logic [CNT_W-1:0] cfg_addr_setup,
  input  logic [CNT_W-1:0] cfg_data_setup,
  input  logic             tmr_last,
  output logic             accept,
  output logic             strobe_end,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output lcd_phase_e       phase_q,
  output lcd_phase_e       phase_d
);
  logic [CNT_W-1:0] dsu_q;

  always_comb begin
    phase_d    = phase_q;
    accept     = 1'b0;
    strobe_end = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = cfg_addr_setup;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = cfg_addr_setup;
          phase_d  = PH_ADDR;
        end
      end
      PH_ADDR: begin
        if (tmr_last) begin
          tmr_load = 1'b1;
          tmr_val  = dsu_q;
          phase_d  = PH_STRB;
        end
      end
      PH_STRB: begin
        if (tmr_last) begin
          strobe_end = 1'b1;
          phase_d    = PH_DONE;
        end
      end
      PH_DONE: begin
        if (rsp_ready) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dsu_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) dsu_q <= cfg_data_setup;
    end
  end
endmodule

// File: rtl/lcdbus_datapath.sv
module lcdbus_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              req_read,
  input  logic              req_dc,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic              op_read_q,
  output logic              dc_q,
  output logic [DATA_W-1:0] word_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_read_q <= 1'b0;
      dc_q      <= 1'b1;
      word_q    <= '0;
      rdata_q   <= '0;
    end else begin
      if (accept) begin
        op_read_q <= req_read;
        dc_q      <= req_dc;
        word_q    <= req_wdata;
      end
      if (capture) rdata_q <= bus_in;
    end
  end
endmodule

// File: rtl/lcdbus_master.sv
module lcdbus_master
  import lcdbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_dc,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_addr_setup,
  input  logic [CNT_W-1:0]  cfg_data_setup,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic              lcd_dc,
  output logic [DATA_W-1:0] lcd_dq_o,
  output logic              lcd_dq_oe,
  input  logic [DATA_W-1:0] lcd_dq_i
);
  lcd_phase_e       phase_q, phase_d;
  logic             accept, strobe_end, tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             op_read_q, dc_q, capture;
  logic [DATA_W-1:0] word_q, rdata_q;

  lcdbus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .rsp_ready      (rsp_ready),
    .cfg_addr_setup (cfg_addr_setup),
    .cfg_data_setup (cfg_data_setup),
    .tmr_last       (tmr_last),
    .accept         (accept),
    .strobe_end     (strobe_end),
    .tmr_load       (tmr_load),
    .tmr_val        (tmr_val),
    .phase_q        (phase_q),
    .phase_d        (phase_d)
  );

  lcdbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  // sample the bus on the edge that ends the read strobe
  assign capture = strobe_end && op_read_q;

  lcdbus_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_read  (req_read),
    .req_dc    (req_dc),
    .req_wdata (req_wdata),
    .bus_in    (lcd_dq_i),
    .op_read_q (op_read_q),
    .dc_q      (dc_q),
    .word_q    (word_q),
    .rdata_q   (rdata_q)
  );

  // pin controls come straight from flops, decoded from the next phase
  logic op_nx, act_nx;
  logic cs_n_q, wr_n_q, rd_n_q, oe_q, busy_q;

  assign op_nx  = accept ? req_read : op_read_q;
  assign act_nx = phase_active(phase_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      cs_n_q <= !act_nx;
      wr_n_q <= !((phase_d == PH_STRB) && !op_nx);
      rd_n_q <= !((phase_d == PH_STRB) && op_nx);
      oe_q   <= act_nx && !op_nx;
      busy_q <= act_nx;
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_valid = (phase_q == PH_DONE);
  assign rsp_rdata = rdata_q;
  assign busy      = busy_q;
  assign lcd_cs_n  = cs_n_q;
  assign lcd_wr_n  = wr_n_q;
  assign lcd_rd_n  = rd_n_q;
  assign lcd_dc    = dc_q;
  assign lcd_dq_o  = word_q;
  assign lcd_dq_oe = oe_q;
endmodule

// File: rtl/lcdbus_master_chk.sv
module lcdbus_master_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              busy,
  input logic              lcd_cs_n,
  input logic              lcd_wr_n,
  input logic              lcd_rd_n,
  input logic              lcd_dc,
  input logic [DATA_W-1:0] lcd_dq_o,
  input logic              lcd_dq_oe
);
  assert_strobes_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lcd_wr_n && !lcd_rd_n));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);

  assert_dc_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_dc));

  assert_wdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_dq_oe && $past(lcd_dq_oe)) |-> $stable(lcd_dq_o));

  assert_no_drive_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_cs_n |-> !lcd_dq_oe);

  assert_no_drive_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> !lcd_dq_oe);

  assert_busy_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !lcd_cs_n);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lcd_cs_n && !rsp_valid));

  assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_wr_n) || $rose(lcd_rd_n)) |-> (lcd_cs_n && rsp_valid));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind lcdbus_master lcdbus_master_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .busy      (busy),
  .lcd_cs_n  (lcd_cs_n),
  .lcd_wr_n  (lcd_wr_n),
  .lcd_rd_n  (lcd_rd_n),
  .lcd_dc    (lcd_dc),
  .lcd_dq_o  (lcd_dq_o),
  .lcd_dq_oe (lcd_dq_oe)
);

// File: tb/tb_lcdbus_master.sv
`timescale 1ns/100ps
module tb_lcdbus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0, req_dc = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  cfg_addr_setup = '0, cfg_data_setup = '0;
  logic        rsp_ready = 1'b0;
  logic [15:0] lcd_dq_i = '0;
  logic        req_ready, rsp_valid, busy, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc, lcd_dq_oe;
  logic [15:0] rsp_rdata, lcd_dq_o;

  always #2.5 clk = ~clk;

  lcdbus_master dut (.*);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // display-side read model: the word advances every strobe clock
  logic [15:0] rd_base = '0;
  int          rd_seen = 0;
  always @(negedge clk) begin
    if (!lcd_rd_n) begin
      lcd_dq_i = rd_base + 16'(rd_seen);
      rd_seen++;
    end else begin
      rd_seen = 0;
    end
  end

  // pin monitor, sampled at the falling edge
  int   cs_cnt, setup_cnt, wr_cnt, rd_cnt, busy_cnt, after_strobe;
  bit   dc_seen, dc_bad, oe_bad;
  logic exp_rd;
  logic [15:0] exp_w;
  int   hi_run = 0, last_gap = 0, min_gap = 1000, cs_falls = 0;
  logic prev_cs_n = 1'b1;

  task automatic mon_clear();
    cs_cnt = 0; setup_cnt = 0; wr_cnt = 0; rd_cnt = 0; busy_cnt = 0;
    after_strobe = 0; dc_seen = 1'b0; dc_bad = 1'b0; oe_bad = 1'b0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (busy) busy_cnt++;
    if (!lcd_cs_n) begin
      if (prev_cs_n) begin
        last_gap = hi_run;
        if (hi_run < min_gap) min_gap = hi_run;
        cs_falls++;
      end
      hi_run = 0;
      cs_cnt++;
      if (lcd_wr_n && lcd_rd_n) begin
        if (wr_cnt + rd_cnt == 0) setup_cnt++;
        else after_strobe++;
      end
      if (!lcd_wr_n) wr_cnt++;
      if (!lcd_rd_n) rd_cnt++;
      if (!dc_seen) begin
        dc_seen = 1'b1;
        dc_seen = dc_seen;
      end
      if (exp_rd ? lcd_dq_oe : (!lcd_dq_oe || lcd_dq_o !== exp_w)) oe_bad = 1'b1;
    end else begin
      hi_run++;
      if (lcd_dq_oe) oe_bad = 1'b1;
    end
    prev_cs_n = lcd_cs_n;
  end

  logic dc_first;
  always @(negedge clk) if (rst_n && !lcd_cs_n) begin
    if (cs_cnt == 1) dc_first = lcd_dc;
    else if (lcd_dc !== dc_first) dc_bad = 1'b1;
  end

  typedef struct packed {
    logic        rd;
    logic        dc;
    logic [15:0] w;
    logic [3:0]  asu;
    logic [3:0]  dsu;
    logic [15:0] base;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b0, 16'h002C, 4'd1,  4'd1,  16'h0000},
    '{1'b0, 1'b1, 16'hF81F, 4'd3,  4'd2,  16'h0000},
    '{1'b1, 1'b1, 16'h0000, 4'd2,  4'd4,  16'h1230},
    '{1'b0, 1'b1, 16'h07E0, 4'd0,  4'd0,  16'h0000},
    '{1'b1, 1'b0, 16'h0000, 4'd0,  4'd0,  16'hBEEF},
    '{1'b0, 1'b1, 16'h001F, 4'd15, 4'd15, 16'h0000},
    '{1'b1, 1'b1, 16'h0000, 4'd5,  4'd15, 16'h0100},
    '{1'b0, 1'b0, 16'h0029, 4'd2,  4'd0,  16'h0000}
  };

  logic [15:0] last_rd = 16'h0000;

  task automatic run_vec(input int idx, input vec_t v);
    int a, d;
    logic [15:0] exp_data;
    a = (v.asu == 0) ? 1 : int'(v.asu);
    d = (v.dsu == 0) ? 1 : int'(v.dsu);
    @(posedge clk);
    mon_clear();
    exp_rd = v.rd; exp_w = v.w; rd_base = v.base;
    @(negedge clk);
    req_valid = 1'b1; req_read = v.rd; req_dc = v.dc; req_wdata = v.w;
    cfg_addr_setup = v.asu; cfg_data_setup = v.dsu;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: alter the timing inputs while the cycle runs
    cfg_addr_setup = ~v.asu; cfg_data_setup = ~v.dsu;
    while (!rsp_valid) @(negedge clk);
    chk($sformatf("R3 setup clocks v%0d", idx), setup_cnt, a);
    chk($sformatf("R3 dc level v%0d", idx), {dc_first, dc_bad}, {v.dc, 1'b0});
    chk($sformatf("R4 strobe clocks v%0d", idx), v.rd ? rd_cnt : wr_cnt, d);
    chk($sformatf("R4 idle strobe v%0d", idx), v.rd ? wr_cnt : rd_cnt, 0);
    chk($sformatf("R10 cs low clocks v%0d", idx), cs_cnt, a + d);
    chk($sformatf("R2 busy clocks v%0d", idx), busy_cnt, a + d);
    chk($sformatf("R5 R6 bus drive v%0d", idx), oe_bad, 0);
    chk($sformatf("R8 cs after strobe v%0d", idx), {lcd_cs_n, 24'(after_strobe)}, {1'b1, 24'd0});
    if (v.rd) last_rd = v.base + 16'(d - 1);
    exp_data = last_rd;
    chk($sformatf("%s rdata v%0d", v.rd ? "R6" : "R9", idx), rsp_rdata, exp_data);
    if (v.asu == 0 || v.dsu == 0)
      chk($sformatf("R7 zero count v%0d", idx), cs_cnt, a + d);
    repeat (2) @(negedge clk);
    chk($sformatf("R8 response held v%0d", idx), {rsp_valid, req_ready, rsp_rdata}, {1'b1, 1'b0, exp_data});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk($sformatf("R8 released v%0d", idx), {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    exp_rd = 1'b0; exp_w = '0; dc_first = 1'b1;
    mon_clear();
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1 pins in reset", {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 handshake after reset", {req_ready, rsp_valid, busy}, 3'b100);
    chk("R1 rdata after reset", rsp_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) run_vec(i, VT[i]);

    // R7: both counts zero, exactly two clocks of chip select
    run_vec(100, '{1'b0, 1'b1, 16'hA5A5, 4'd0, 4'd0, 16'h0});
    chk("R7 minimum cycle", cs_cnt, 2);

    // R8: back-to-back writes with the response always consumed
    @(posedge clk);
    mon_clear();
    cs_falls = 0; min_gap = 1000;
    exp_rd = 1'b0; exp_w = 16'h1111;
    @(negedge clk);
    rsp_ready = 1'b1;
    req_valid = 1'b1; req_read = 1'b0; req_dc = 1'b1; req_wdata = 16'h1111;
    cfg_addr_setup = 4'd0; cfg_data_setup = 4'd0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_w = 16'h2222; req_wdata = 16'h2222;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 two cycles seen", cs_falls, 2);
    chk("R8 gap at least one", (min_gap >= 1) ? 1 : 0, 1);
    chk("R9 rdata kept over writes", rsp_rdata, last_rd);
    chk("R5 no drive when idle", oe_bad, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule